// File: doc/BRIEF.md
# SDI Sync Bit Inserter and Remover

This block sits on the 10-bit word-multiplexed stream of a serial digital video link. The transmit half runs just before serialisation. In every timing reference sequence it inverts bit 1 of most preamble words. The result is that the long all-ones and all-zeros stretches of the preamble cannot form excessive serial runs. It leaves one short `3FFh, 000h, 000h` triplet as it was, so the receiver can still find word framing.

The receive half watches its own input for that triplet. When it appears, the block restores the words that the transmitter altered: the seven words before the triplet go back to `3FFh` and the fourteen words after it go back to `000h`. The receive half keeps a ten-word history line so that it can reach the words before the triplet.

Each half is a pass-through stream. `*_in_ready` equals `*_out_ready`, and `*_out_valid` equals `*_in_valid`. A word is accepted exactly when valid and ready are both high. Each accepted word pushes one older word out on the same handshake. When ready is low, or when valid is low, nothing moves and the output word holds. Because of this, a sparse enable cadence (for example one word in eleven clocks) is carried unchanged.

Top module: `sdi_sync_codec`

## Requirements
- R1: In the transmit path, the word that carries `tx_trs_start` (position 0) and the words at positions 1 to 6 after it leave with bit 1 cleared (`3FFh` becomes `3FDh`).
- R2: Transmit positions 7, 8 and 9 leave unchanged, so the `3FFh, 000h, 000h` triplet survives.
- R3: Transmit positions 10 to 23 leave with bit 1 set (`000h` becomes `002h`).
- R4: Transmit words at position 24 and beyond, and words outside any strobed sequence, leave bit-exact. This holds even when their value is `3FFh`, `000h`, `3FDh` or `002h`.
- R5: The transmit output is one accepted word behind its input. After reset, the transmit output word is `000h`.
- R6: The receive output is ten accepted words behind its input, and words outside a restore window pass bit-exact. After reset, the first ten receive outputs are `000h`.
- R7: When the receive input completes a `3FFh, 000h, 000h` triplet, each of the seven words before the `3FFh` that equals `3FDh` leaves as `3FFh`.
- R8: After a triplet, each of the next fourteen receive words that equals `002h` leaves as `000h`.
- R9: Inside either restore window, a receive word with any other value leaves unchanged.
- R10: `*_in_ready` follows `*_out_ready`. Without a handshake, neither path advances and its output word holds.
- R11: An encoded-then-decoded stream of random lines with EAV and SAV sequences returns every word bit-exact. Each sequence yields seven `3FDh` and fourteen `002h` words. The longest serial run, sent LSB first, is 18 ones and 21 zeros.
- R12: Each output word differs from the input word it came from in bit 1 at most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Transmit input word valid |
| tx_in_ready | output | 1 | Transmit input may be accepted |
| tx_in_data | input | W | Transmit input word |
| tx_trs_start | input | 1 | Marks the first preamble word of an EAV or SAV sequence |
| tx_out_valid | output | 1 | Transmit output word valid |
| tx_out_ready | input | 1 | Downstream accepts the transmit word |
| tx_out_data | output | W | Transmit output word, sync bits inserted |
| rx_in_valid | input | 1 | Receive input word valid |
| rx_in_ready | output | 1 | Receive input may be accepted |
| rx_in_data | input | W | Receive input word |
| rx_out_valid | output | 1 | Receive output word valid |
| rx_out_ready | input | 1 | Downstream accepts the receive word |
| rx_out_data | output | W | Receive output word, original values restored |

## Verification
The hardest case to reach is the receive rewrite of words that already sit deep in the history line. It has to happen at the moment the second kept zero arrives, including when some of those words carry unexpected values or the stream stalls part-way through. The bench drives hand-built encoded preambles straight into the receive port. One pass holds the receive path back for several cycles in the middle of the restore window. Another plants `3FCh` among the words before the triplet and `006h` among the words after it. A long loopback of random lines then checks the round trip, the per-sequence rewrite counts and the serial run bounds together.

// File: rtl/sdi_sync_pkg.sv
`timescale 1ns/1ps
package sdi_sync_pkg;
  localparam int unsigned DEF_WORD_W = 10;  // multiplexed word width
  localparam int unsigned DEF_ONES   = 8;   // all-ones words per preamble
  localparam int unsigned DEF_ZEROS  = 16;  // all-zeros words per preamble
  localparam int unsigned DEF_KEEP   = 2;   // zero words kept beside the last ones word
  localparam int unsigned DEF_FLIP   = 1;   // bit position that is toggled

  // Segment of the preamble that a transmit word falls into
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_CLR  = 2'd1,
    SEG_KEEP = 2'd2,
    SEG_SET  = 2'd3
  } seg_e;
endpackage

// File: rtl/sdi_sync_tx_ins.sv
`timescale 1ns/1ps
module sdi_sync_tx_ins
  import sdi_sync_pkg::*;
#(
  parameter int unsigned W     = DEF_WORD_W,
  parameter int unsigned ONES  = DEF_ONES,
  parameter int unsigned ZEROS = DEF_ZEROS,
  parameter int unsigned KEEP  = DEF_KEEP,
  parameter int unsigned FLIP  = DEF_FLIP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned LEN     = ONES + ZEROS;
  localparam int unsigned PW      = $clog2(LEN + 1);
  localparam int unsigned CLR_END = ONES - 1;     // first kept position
  localparam int unsigned SET_BEG = ONES + KEEP;  // first set position

  logic [PW-1:0] pos_q, pos_now;
  logic          live_q, live_now;
  seg_e          seg;
  logic [W-1:0]  word;

  // a strobe restarts the count on its own word
  assign live_now = strobe | live_q;
  assign pos_now  = strobe ? '0 : pos_q;

  always_comb begin
    if (!live_now)                    seg = SEG_IDLE;
    else if (pos_now < PW'(CLR_END))  seg = SEG_CLR;
    else if (pos_now < PW'(SET_BEG))  seg = SEG_KEEP;
    else                              seg = SEG_SET;
    word = din;
    case (seg)
      SEG_CLR: word[FLIP] = 1'b0;
      SEG_SET: word[FLIP] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout   <= '0;
      pos_q  <= '0;
      live_q <= 1'b0;
    end else if (adv) begin
      dout <= word;
      if (live_now) begin
        if (pos_now == PW'(LEN - 1)) begin
          live_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          live_q <= 1'b1;
          pos_q  <= pos_now + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdi_sync_rx_rest.sv
`timescale 1ns/1ps
module sdi_sync_rx_rest
  import sdi_sync_pkg::*;
#(
  parameter int unsigned W     = DEF_WORD_W,
  parameter int unsigned ONES  = DEF_ONES,
  parameter int unsigned ZEROS = DEF_ZEROS,
  parameter int unsigned KEEP  = DEF_KEEP,
  parameter int unsigned FLIP  = DEF_FLIP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned HIST    = ONES + KEEP;   // history line depth
  localparam int unsigned RESTORE = ZEROS - KEEP;  // zero words to restore
  localparam int unsigned CW      = $clog2(RESTORE + 1);
  localparam logic [W-1:0] ALL1     = '1;
  localparam logic [W-1:0] SET_WORD = W'(1) << FLIP;
  localparam logic [W-1:0] CLR_WORD = ALL1 & ~SET_WORD;

  logic [W-1:0]    sr  [HIST];
  logic [W-1:0]    nxt [HIST];
  logic [KEEP-1:0] zok;
  logic            hit;
  logic [CW-1:0]   zcnt;

  // triplet completes when the incoming word is the last kept zero
  assign zok[0] = (din == '0);
  for (genvar k = 1; k < KEEP; k++) begin : g_zero
    assign zok[k] = (sr[k-1] == '0);
  end
  assign hit = (&zok) && (sr[KEEP-1] == ALL1);

  // entry stage: restore zero words while the window is open
  assign nxt[0] = ((zcnt != '0) && (din == SET_WORD)) ? '0 : din;

  // later stages: words behind the ones word are restored on a hit
  for (genvar i = 1; i < HIST; i++) begin : g_stage
    if (i > KEEP) begin : g_fix
      assign nxt[i] = (hit && (sr[i-1] == CLR_WORD)) ? ALL1 : sr[i-1];
    end else begin : g_pass
      assign nxt[i] = sr[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) sr[i] <= '0;
      zcnt <= '0;
    end else if (adv) begin
      for (int i = 0; i < HIST; i++) sr[i] <= nxt[i];
      if (hit)               zcnt <= CW'(RESTORE);
      else if (zcnt != '0)   zcnt <= zcnt - CW'(1);
    end
  end

  assign dout = sr[HIST-1];
endmodule

// File: rtl/sdi_sync_codec.sv
`timescale 1ns/1ps
module sdi_sync_codec
  import sdi_sync_pkg::*;
#(
  parameter int unsigned W     = DEF_WORD_W,
  parameter int unsigned ONES  = DEF_ONES,
  parameter int unsigned ZEROS = DEF_ZEROS,
  parameter int unsigned KEEP  = DEF_KEEP,
  parameter int unsigned FLIP  = DEF_FLIP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_in_valid,
  output logic         tx_in_ready,
  input  logic [W-1:0] tx_in_data,
  input  logic         tx_trs_start,
  output logic         tx_out_valid,
  input  logic         tx_out_ready,
  output logic [W-1:0] tx_out_data,
  input  logic         rx_in_valid,
  output logic         rx_in_ready,
  input  logic [W-1:0] rx_in_data,
  output logic         rx_out_valid,
  input  logic         rx_out_ready,
  output logic [W-1:0] rx_out_data
);
  logic tx_adv, rx_adv;

  // pass-through handshake: one word in pushes one word out
  assign tx_in_ready  = tx_out_ready;
  assign tx_out_valid = tx_in_valid;
  assign tx_adv       = tx_in_valid & tx_out_ready;
  assign rx_in_ready  = rx_out_ready;
  assign rx_out_valid = rx_in_valid;
  assign rx_adv       = rx_in_valid & rx_out_ready;

  sdi_sync_tx_ins #(
    .W(W), .ONES(ONES), .ZEROS(ZEROS), .KEEP(KEEP), .FLIP(FLIP)
  ) u_ins (
    .clk(clk), .rst_n(rst_n), .adv(tx_adv), .strobe(tx_trs_start),
    .din(tx_in_data), .dout(tx_out_data)
  );

  sdi_sync_rx_rest #(
    .W(W), .ONES(ONES), .ZEROS(ZEROS), .KEEP(KEEP), .FLIP(FLIP)
  ) u_rest (
    .clk(clk), .rst_n(rst_n), .adv(rx_adv),
    .din(rx_in_data), .dout(rx_out_data)
  );
endmodule

// File: rtl/sdi_sync_codec_chk.sv
`timescale 1ns/1ps
module sdi_sync_codec_chk #(
  parameter int unsigned W    = 10,
  parameter int unsigned ONES = 8,
  parameter int unsigned KEEP = 2,
  parameter int unsigned FLIP = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_in_valid,
  input logic [W-1:0] tx_in_data,
  input logic         tx_out_ready,
  input logic [W-1:0] tx_out_data,
  input logic         rx_in_valid,
  input logic [W-1:0] rx_in_data,
  input logic         rx_out_ready,
  input logic [W-1:0] rx_out_data
);
  localparam int unsigned HIST = ONES + KEEP;
  localparam logic [W-1:0] MASK = ~(W'(1) << FLIP);

  logic [W-1:0] tx_prev;
  logic [W-1:0] hist [HIST];
  logic tx_go, rx_go;

  assign tx_go = tx_in_valid & tx_out_ready;
  assign rx_go = rx_in_valid & rx_out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_prev <= '0;
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else begin
      if (tx_go) tx_prev <= tx_in_data;
      if (rx_go) begin
        hist[0] <= rx_in_data;
        for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
      end
    end
  end

  // R12
  tx_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> (((tx_out_data ^ tx_prev) & MASK) == '0));

  // R12
  rx_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_go |-> (((rx_out_data ^ hist[HIST-1]) & MASK) == '0));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_go |=> $stable(tx_out_data));

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_go |=> $stable(rx_out_data));
endmodule

bind sdi_sync_codec sdi_sync_codec_chk #(
  .W(W), .ONES(ONES), .KEEP(KEEP), .FLIP(FLIP)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
  .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
  .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
  .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
);

// File: tb/sdi_sync_codec_bench.sv
`timescale 1ns/1ps
module sdi_sync_codec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       tx_in_valid = 1'b0, tx_trs_start = 1'b0, tx_rdy_drv = 1'b1;
  logic [9:0] tx_in_data = '0;
  logic       loop = 1'b0, rx_drv_valid = 1'b0, rx_out_ready = 1'b1;
  logic [9:0] rx_drv_data = '0;
  wire        tx_in_ready, tx_out_valid, tx_out_ready;
  wire        rx_in_valid, rx_in_ready, rx_out_valid;
  wire [9:0]  tx_out_data, rx_in_data, rx_out_data;

  assign tx_out_ready = loop ? rx_in_ready  : tx_rdy_drv;
  assign rx_in_valid  = loop ? tx_out_valid : rx_drv_valid;
  assign rx_in_data   = loop ? tx_out_data  : rx_drv_data;

  sdi_sync_codec u_sdi_sync_codec (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_trs_start(tx_trs_start), .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic push(input bit tv, input bit s, input logic [9:0] tw,
                      input bit rv, input logic [9:0] rw,
                      output logic [9:0] to, output logic [9:0] ro);
    @(negedge clk);
    tx_in_valid = tv; tx_trs_start = s; tx_in_data = tw;
    rx_drv_valid = rv; rx_drv_data = rw;
    #1;
    to = tx_out_data;
    ro = rx_out_data;
    @(posedge clk);
    #1;
    tx_in_valid = 1'b0; tx_trs_start = 1'b0; rx_drv_valid = 1'b0;
  endtask

  // transmit vectors: strobe, input word, expected output word
  typedef struct packed { logic s; logic [9:0] din; logic [9:0] exp; } vec_t;
  localparam vec_t VEC [36] = '{
    '{1'b1,10'h3FF,10'h3FD}, '{1'b0,10'h3FF,10'h3FD}, '{1'b0,10'h3FF,10'h3FD}, '{1'b0,10'h3FF,10'h3FD},
    '{1'b0,10'h3FF,10'h3FD}, '{1'b0,10'h3FF,10'h3FD}, '{1'b0,10'h3FF,10'h3FD}, '{1'b0,10'h3FF,10'h3FF},
    '{1'b0,10'h000,10'h000}, '{1'b0,10'h000,10'h000}, '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002},
    '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002},
    '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002},
    '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002}, '{1'b0,10'h000,10'h002},
    '{1'b0,10'h274,10'h274}, '{1'b0,10'h274,10'h274}, '{1'b0,10'h274,10'h274}, '{1'b0,10'h274,10'h274},
    '{1'b0,10'h2D8,10'h2D8}, '{1'b0,10'h2D8,10'h2D8}, '{1'b0,10'h2D8,10'h2D8}, '{1'b0,10'h2D8,10'h2D8},
    '{1'b0,10'h3FF,10'h3FF}, '{1'b0,10'h000,10'h000}, '{1'b0,10'h3FD,10'h3FD}, '{1'b0,10'h002,10'h002}
  };

  // receive directed run: encoded preamble straight into the receive port
  task automatic rx_run(input bit corrupt, input logic [9:0] pre);
    logic [9:0] enc [44];
    logic [9:0] org [44];
    logic [9:0] to, ro, hold;
    int idx;
    for (int k = 0; k < 44; k++) begin
      if (k < 4)       begin enc[k] = 10'h040; org[k] = 10'h040; end
      else if (k < 11) begin enc[k] = 10'h3FD; org[k] = 10'h3FF; end
      else if (k < 12) begin enc[k] = 10'h3FF; org[k] = 10'h3FF; end
      else if (k < 14) begin enc[k] = 10'h000; org[k] = 10'h000; end
      else if (k < 28) begin enc[k] = 10'h002; org[k] = 10'h000; end
      else if (k < 32) begin enc[k] = 10'h274; org[k] = 10'h274; end
      else             begin enc[k] = 10'h100; org[k] = 10'h100; end
    end
    if (corrupt) begin
      enc[6] = 10'h3FC;  org[6] = 10'h3FC;
      enc[19] = 10'h006; org[19] = 10'h006;
    end
    for (int k = 0; k < 44; k++) begin
      if (k == 20 && !corrupt) begin
        // R10: stall the receive path inside the restore window
        @(negedge clk);
        rx_drv_valid = 1'b1; rx_drv_data = enc[20]; rx_out_ready = 1'b0;
        #1 hold = rx_out_data;
        for (int c = 0; c < 3; c++) begin
          @(negedge clk);
          #1;
          chk(rx_in_ready == 1'b0, "R10 ready", int'(rx_in_ready), 0);
          chk(rx_out_data == hold, "R10 hold", int'(rx_out_data), int'(hold));
        end
        rx_out_ready = 1'b1; rx_drv_valid = 1'b0;
      end
      push(1'b0, 1'b0, 10'h000, 1'b1, enc[k], to, ro);
      idx = k - 10;
      if (k < 10)
        chk(ro == pre, "R6 fill", int'(ro), int'(pre));
      else if (corrupt && (idx == 6 || idx == 19))
        chk(ro == org[idx], "R9", int'(ro), int'(org[idx]));
      else if (idx >= 4 && idx <= 10)
        chk(ro == org[idx], "R7", int'(ro), int'(org[idx]));
      else if (idx >= 14 && idx <= 27)
        chk(ro == org[idx], "R8", int'(ro), int'(org[idx]));
      else
        chk(ro == org[idx], "R6", int'(ro), int'(org[idx]));
    end
  endtask

  // loopback stream
  localparam int LB_N = 5 * 104 + 11;
  logic [9:0] src [LB_N];
  logic       stb [LB_N];
  logic [9:0] tl  [LB_N];
  logic [9:0] rl  [LB_N];
  int p = 0;

  task automatic put(input logic [9:0] w, input bit s);
    src[p] = w; stb[p] = s; p++;
  endtask

  task automatic put_trs();
    for (int i = 0; i < 8; i++)  put(10'h3FF, i == 0);
    for (int i = 0; i < 16; i++) put(10'h000, 1'b0);
    for (int i = 0; i < 8; i++)  put(10'(10'h200 + ($urandom % 10'h1F0)), 1'b0);
  endtask

  task automatic put_act(input int n);
    for (int i = 0; i < n; i++) put(10'(10'h004 + ($urandom % 10'h3EC)), 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [9:0] to, ro;
    int n3fd, n002, run, maxo, maxz;
    logic lastb;
    string tag;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(tx_out_data == 10'h000, "R5 reset", int'(tx_out_data), 0);
    chk(rx_out_data == 10'h000, "R6 reset", int'(rx_out_data), 0);
    chk(tx_in_ready == 1'b1, "R10 ready", int'(tx_in_ready), 1);

    // transmit table walk: output at step i belongs to input i-1
    for (int i = 0; i <= 36; i++) begin
      if (i < 36) push(1'b1, VEC[i].s, VEC[i].din, 1'b0, 10'h000, to, ro);
      else        push(1'b1, 1'b0, 10'h000, 1'b0, 10'h000, to, ro);
      if (i == 0) chk(to == 10'h000, "R5", int'(to), 0);
      else begin
        if (i - 1 < 7)       tag = "R1";
        else if (i - 1 < 10) tag = "R2";
        else if (i - 1 < 24) tag = "R3";
        else                 tag = "R4";
        chk(to == VEC[i-1].exp, tag, int'(to), int'(VEC[i-1].exp));
      end
    end

    // R10: transmit holds without valid and without ready
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_data = 10'h3AA; tx_rdy_drv = 1'b0;
    @(negedge clk);
    chk(tx_in_ready == 1'b0, "R10 ready", int'(tx_in_ready), 0);
    chk(tx_out_data == 10'h000, "R10 hold", int'(tx_out_data), 0);
    tx_in_valid = 1'b0; tx_rdy_drv = 1'b1;
    @(negedge clk);
    chk(tx_out_data == 10'h000, "R10 hold", int'(tx_out_data), 0);

    // receive restoration, clean then corrupted
    rx_run(1'b0, 10'h000);
    rx_run(1'b1, 10'h100);

    // R11 loopback of random lines
    for (int l = 0; l < 5; l++) begin
      put_trs(); put_act(16); put_trs(); put_act(24);
    end
    while (p < LB_N) put(10'h100, 1'b0);
    loop = 1'b1; rx_out_ready = 1'b1;
    for (int k = 0; k < LB_N; k++)
      push(1'b1, stb[k], src[k], 1'b0, 10'h000, tl[k], rl[k]);
    for (int k = 11; k < LB_N; k++)
      chk(rl[k] == src[k-11], "R11 round trip", int'(rl[k]), int'(src[k-11]));
    n3fd = 0; n002 = 0; run = 0; maxo = 0; maxz = 0; lastb = 1'b0;
    for (int k = 1; k < LB_N; k++) begin
      if (tl[k] == 10'h3FD) n3fd++;
      if (tl[k] == 10'h002) n002++;
      for (int b = 0; b < 10; b++) begin
        if (run != 0 && tl[k][b] == lastb) run++;
        else run = 1;
        lastb = tl[k][b];
        if (lastb && run > maxo)  maxo = run;
        if (!lastb && run > maxz) maxz = run;
      end
    end
    chk(n3fd == 70,  "R11 3FD count", n3fd, 70);
    chk(n002 == 140, "R11 002 count", n002, 140);
    chk(maxo == 18,  "R11 ones run", maxo, 18);
    chk(maxz == 21,  "R11 zeros run", maxz, 21);

    summary();
  end
endmodule